// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block keeps the calendar and clock of a real-time clock as packed BCD bytes: seconds, minutes, hours, weekday with a century flag, date, month and two-digit year, plus one control byte. A one-second `tick` pulse moves the time forward. Carries ripple from seconds up to the year. Month lengths follow a small lookup with a divisible-by-four leap rule.

Software reaches the eight registers through a byte port. A write is a single `wr_en` cycle. A read is combinational on `addr`. Each write is checked before it is stored: a value outside the legal BCD range of its field leaves that field as it was. Bit 7 of the seconds register is a stop flag. While it is set, ticks are ignored.

There is no streaming data path. Every access completes in the cycle it is presented, so the port needs no valid/ready handshake and never applies back-pressure.

Top module: `bcd_tod_regfile`

## Requirements
- R1: After reset the registers read: offset 0 = 0x90, seconds 0x00, minutes 0x00, hours 0x00, offset 4 = 0x01, date 0x01, month 0x01, year 0x00, and the stop flag is clear.
- R2: Offsets are 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year. An accepted write reads back as the masked value.
- R3: A write to offset 0 stores the written byte with bits 7 and 5 cleared and then bits 7 and 4 set, i.e. (v & 0x5F) | 0x90.
- R4: Seconds and minutes take bits 6:0, and hours take bits 5:0. The write is accepted only when both BCD nibbles are 0 to 9 and the value is at most 0x59 (seconds, minutes) or 0x23 (hours). Otherwise the field keeps its value.
- R5: Date takes bits 5:0 and must be 0x01 to 0x31. Month takes bits 4:0 and must be 0x01 to 0x12. Year takes all 8 bits and must be 0x00 to 0x99. All three must be valid BCD. A rejected write changes nothing.
- R6: Bit 7 of a seconds write is always stored as the stop flag, even when the seconds value is rejected. The flag reads back in bit 7 of offset 1, together with the seconds. While it is set, ticks do not advance the time. Clearing it resumes from the frozen value.
- R7: Each tick with the stop flag clear adds one to the BCD seconds (0x09 goes to 0x10). 0x59 goes to 0x00 and carries into the minutes. Minutes at 0x59 carry into the hours. Hours at 0x23 carry into the day.
- R8: A day carry moves the date from the month's last day to 0x01 and increments the month. Month 0x12 goes to 0x01 and increments the year. Year 0x99 goes to 0x00.
- R9: Months 0x04, 0x06, 0x09 and 0x11 have 30 days. February has 29 days when the year is divisible by four (0x00 and 0x12 count, 0x10 and 0x13 do not), and 28 otherwise. All other months have 31 days.
- R10: Offset 4 stores the weekday from bits 2:0 and a century flag from bit 6, with no check. It reads back as century in bit 6 and weekday in bits 2:0, other bits zero. A day carry advances the weekday, and 7 wraps to 1.
- R11: When a write and a tick fall in the same cycle, the written field takes the written value. Carries are computed from the values held before that cycle, so the other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
The hardest states to reach are the calendar edges: the leap day, the end of a 30-day month and the turn of the century. Reaching them from reset through ticks alone would take years of seconds. The stimulus therefore loads year, month, date, hours, minutes and seconds through the validated write path to one second before the boundary, then gives a single tick. Resuming a frozen clock without disturbing its seconds is also awkward to reach. It is done by writing an out-of-range seconds value with bit 7 clear: the value is rejected, but the stop flag is still cleared.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int OFS_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int FIELD_N = 6;

  // register offsets (software-visible order)
  localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_SEC   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_MIN   = 3'd2;
  localparam logic [OFS_W-1:0] OFS_HOUR  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_WDAY  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_DATE  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MONTH = 3'd6;
  localparam logic [OFS_W-1:0] OFS_YEAR  = 3'd7;

  // counting fields, in carry order
  localparam int FI_SEC   = 0;
  localparam int FI_MIN   = 1;
  localparam int FI_HOUR  = 2;
  localparam int FI_DATE  = 3;
  localparam int FI_MONTH = 4;
  localparam int FI_YEAR  = 5;

  localparam logic [OFS_W-1:0]  FLD_OFS  [FIELD_N] = '{OFS_SEC, OFS_MIN, OFS_HOUR, OFS_DATE, OFS_MONTH, OFS_YEAR};
  localparam logic [BYTE_W-1:0] FLD_MASK [FIELD_N] = '{8'h7F, 8'h7F, 8'h3F, 8'h3F, 8'h1F, 8'hFF};
  localparam logic [BYTE_W-1:0] FLD_LO   [FIELD_N] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
  localparam logic [BYTE_W-1:0] FLD_HI   [FIELD_N] = '{8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99};
  localparam logic [BYTE_W-1:0] FLD_RST  [FIELD_N] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};

  localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'h5F;
  localparam logic [BYTE_W-1:0] CTRL_SET  = 8'h90;

  function automatic logic digits_ok(input logic [BYTE_W-1:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  function automatic logic [BYTE_W-1:0] bcd_plus1(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/tod_bcd_step.sv
module tod_bcd_step
  import tod_pkg::*;
(
  input  logic [BYTE_W-1:0] cur,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  input  logic              inc,
  output logic [BYTE_W-1:0] nxt,
  output logic              wrap
);
  logic at_top;
  assign at_top = (cur >= hi);

  always_comb begin
    wrap = inc && at_top;
    if (!inc)        nxt = cur;
    else if (at_top) nxt = lo;
    else             nxt = bcd_plus1(cur);
  end
endmodule

// File: rtl/tod_month_len.sv
module tod_month_len
  import tod_pkg::*;
(
  input  logic [BYTE_W-1:0] month,
  input  logic              year_tens_odd,
  input  logic [3:0]        year_units,
  output logic [BYTE_W-1:0] last_day
);
  logic leap;

  // divisible by four in BCD: even tens with units 0/4/8, odd tens with 2/6
  always_comb begin
    if (year_tens_odd) leap = (year_units == 4'd2) || (year_units == 4'd6);
    else               leap = (year_units == 4'd0) || (year_units == 4'd4) || (year_units == 4'd8);
  end

  always_comb begin
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/tod_write_filter.sv
module tod_write_filter
  import tod_pkg::*;
(
  input  logic                           wr_en,
  input  logic [OFS_W-1:0]               addr,
  input  logic [BYTE_W-1:0]              wdata,
  output logic [FIELD_N-1:0]             field_we,
  output logic [FIELD_N-1:0][BYTE_W-1:0] field_val
);
  for (genvar gi = 0; gi < FIELD_N; gi++) begin : g_chk
    logic [BYTE_W-1:0] masked;
    logic              lo_ok;
    logic              hi_ok;
    assign masked = wdata & FLD_MASK[gi];
    if (FLD_LO[gi] == 8'h00) begin : g_nolo
      assign lo_ok = 1'b1;
    end else begin : g_lo
      assign lo_ok = (masked >= FLD_LO[gi]);
    end
    assign hi_ok         = (masked <= FLD_HI[gi]);
    assign field_val[gi] = masked;
    assign field_we[gi]  = wr_en && (addr == FLD_OFS[gi]) && digits_ok(masked) && lo_ok && hi_ok;
  end
endmodule

// File: rtl/tod_read_mux.sv
module tod_read_mux
  import tod_pkg::*;
(
  input  logic [OFS_W-1:0]               addr,
  input  logic [BYTE_W-1:0]              ctrl,
  input  logic                           stop,
  input  logic                           century,
  input  logic [2:0]                     wday,
  input  logic [FIELD_N-1:0][BYTE_W-1:0] fields,
  output logic [BYTE_W-1:0]              rdata
);
  always_comb begin
    case (addr)
      OFS_CTRL:  rdata = ctrl;
      OFS_SEC:   rdata = fields[FI_SEC] | {stop, 7'd0};
      OFS_MIN:   rdata = fields[FI_MIN];
      OFS_HOUR:  rdata = fields[FI_HOUR];
      OFS_WDAY:  rdata = {1'b0, century, 3'd0, wday};
      OFS_DATE:  rdata = fields[FI_DATE];
      OFS_MONTH: rdata = fields[FI_MONTH];
      default:   rdata = fields[FI_YEAR];
    endcase
  end
endmodule

// File: rtl/bcd_tod_regfile.sv
module bcd_tod_regfile
  import tod_pkg::*;
#(
  parameter logic [2:0] RESET_WDAY = 3'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [FIELD_N-1:0][BYTE_W-1:0] field_q;
  logic [FIELD_N-1:0][BYTE_W-1:0] step_nxt;
  logic [FIELD_N-1:0][BYTE_W-1:0] field_val;
  logic [FIELD_N-1:0]             field_we;
  logic [FIELD_N-2:0]             step_wrap;
  logic                           year_wrap_unused;
  logic [BYTE_W-1:0]              ctrl_q;
  logic                           stop_q;
  logic                           cent_q;
  logic [2:0]                     wday_q;
  logic [BYTE_W-1:0]              last_day;
  logic                           run;
  logic                           day_carry;

  assign run       = tick && !stop_q;
  assign day_carry = step_wrap[FI_HOUR];

  tod_month_len u_mlen (
    .month         (field_q[FI_MONTH]),
    .year_tens_odd (field_q[FI_YEAR][4]),
    .year_units    (field_q[FI_YEAR][3:0]),
    .last_day      (last_day)
  );

  tod_write_filter u_wfilt (
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .field_we  (field_we),
    .field_val (field_val)
  );

  for (genvar gi = 0; gi < FIELD_N; gi++) begin : g_field
    logic              inc_w;
    logic [BYTE_W-1:0] hi_w;
    if (gi == 0) begin : g_first
      assign inc_w = run;
    end else begin : g_chain
      assign inc_w = step_wrap[gi-1];
    end
    if (gi == FI_DATE) begin : g_dyn
      assign hi_w = last_day;
    end else begin : g_fix
      assign hi_w = FLD_HI[gi];
    end
    if (gi == FIELD_N-1) begin : g_top
      tod_bcd_step u_step (
        .cur (field_q[gi]), .lo (FLD_LO[gi]), .hi (hi_w), .inc (inc_w),
        .nxt (step_nxt[gi]), .wrap (year_wrap_unused)
      );
    end else begin : g_mid
      tod_bcd_step u_step (
        .cur (field_q[gi]), .lo (FLD_LO[gi]), .hi (hi_w), .inc (inc_w),
        .nxt (step_nxt[gi]), .wrap (step_wrap[gi])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FIELD_N; i++) field_q[i] <= FLD_RST[i];
      ctrl_q <= CTRL_SET;
      stop_q <= 1'b0;
      cent_q <= 1'b0;
      wday_q <= RESET_WDAY;
    end else begin
      for (int i = 0; i < FIELD_N; i++) field_q[i] <= field_we[i] ? field_val[i] : step_nxt[i];
      if (wr_en && addr == OFS_CTRL) ctrl_q <= (wdata & CTRL_KEEP) | CTRL_SET;
      if (wr_en && addr == OFS_SEC)  stop_q <= wdata[7];
      if (wr_en && addr == OFS_WDAY) begin
        wday_q <= wdata[2:0];
        cent_q <= wdata[6];
      end else if (day_carry) begin
        wday_q <= (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
      end
    end
  end

  tod_read_mux u_rmux (
    .addr    (addr),
    .ctrl    (ctrl_q),
    .stop    (stop_q),
    .century (cent_q),
    .wday    (wday_q),
    .fields  (field_q),
    .rdata   (rdata)
  );
endmodule

// File: rtl/tod_regfile_chk.sv
module tod_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       stop_q,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] ctrl_q
);
  // R3
  ctrl_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);

  // R4
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q <= 8'h59) && (sec_q[3:0] <= 4'd9));

  // R4
  sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == 3'd1) && (wdata[6:0] > 7'h59) && !tick |=> $stable(sec_q));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !wr_en |=> $stable(sec_q) && $stable(min_q));

  // R7
  sec_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !stop_q && !wr_en && (sec_q != 8'h59) |=> sec_q != $past(sec_q));
endmodule

bind bcd_tod_regfile tod_regfile_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .stop_q (stop_q),
  .sec_q  (field_q[0]),
  .min_q  (field_q[1]),
  .ctrl_q (ctrl_q)
);

// File: tb/bcd_tod_regfile_bench.sv
`timescale 1ns/1ps
module bcd_tod_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_tod_regfile u_bcd_tod_regfile (
    .clk (clk), .rst_n (rst_n), .tick (tick), .wr_en (wr_en),
    .addr (addr), .wdata (wdata), .rdata (rdata)
  );

  localparam logic [7:0] KW = 8'd0;  // write
  localparam logic [7:0] KR = 8'd1;  // read and compare
  localparam logic [7:0] KT = 8'd2;  // ticks, count in data
  localparam int NVEC = 57;
  // {req, kind, addr, data, expected}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd3, KW, 8'd0, 8'hFF, 8'h00}, {8'd3, KR, 8'd0, 8'h00, 8'hDF},  // R3
    {8'd3, KW, 8'd0, 8'h00, 8'h00}, {8'd3, KR, 8'd0, 8'h00, 8'h90},  // R3
    {8'd2, KW, 8'd1, 8'h45, 8'h00}, {8'd2, KR, 8'd1, 8'h00, 8'h45},  // R2
    {8'd4, KW, 8'd1, 8'h60, 8'h00}, {8'd4, KR, 8'd1, 8'h00, 8'h45},  // R4
    {8'd4, KW, 8'd1, 8'h4A, 8'h00}, {8'd4, KR, 8'd1, 8'h00, 8'h45},  // R4
    {8'd2, KW, 8'd2, 8'h59, 8'h00}, {8'd2, KR, 8'd2, 8'h00, 8'h59},  // R2
    {8'd4, KW, 8'd2, 8'h5F, 8'h00}, {8'd4, KR, 8'd2, 8'h00, 8'h59},  // R4
    {8'd4, KW, 8'd3, 8'h24, 8'h00}, {8'd4, KR, 8'd3, 8'h00, 8'h00},  // R4
    {8'd4, KW, 8'd3, 8'hA3, 8'h00}, {8'd4, KR, 8'd3, 8'h00, 8'h23},  // R4
    {8'd7, KT, 8'd0, 8'd1,  8'h00}, {8'd7, KR, 8'd1, 8'h00, 8'h46},  // R7
    {8'd7, KT, 8'd0, 8'd13, 8'h00}, {8'd7, KR, 8'd1, 8'h00, 8'h59},  // R7
    {8'd7, KT, 8'd0, 8'd1,  8'h00}, {8'd7, KR, 8'd1, 8'h00, 8'h00},  // R7
    {8'd7, KR, 8'd2, 8'h00, 8'h00}, {8'd7, KR, 8'd3, 8'h00, 8'h00},  // R7
    {8'd8, KR, 8'd5, 8'h00, 8'h02}, {8'd10, KR, 8'd4, 8'h00, 8'h02}, // R8 R10
    {8'd7, KW, 8'd1, 8'h09, 8'h00}, {8'd7, KT, 8'd0, 8'd1,  8'h00},  // R7
    {8'd7, KR, 8'd1, 8'h00, 8'h10},                                  // R7
    {8'd5, KW, 8'd5, 8'h00, 8'h00}, {8'd5, KR, 8'd5, 8'h00, 8'h02},  // R5
    {8'd5, KW, 8'd5, 8'h32, 8'h00}, {8'd5, KR, 8'd5, 8'h00, 8'h02},  // R5
    {8'd5, KW, 8'd6, 8'h13, 8'h00}, {8'd5, KW, 8'd6, 8'h00, 8'h00},  // R5
    {8'd5, KR, 8'd6, 8'h00, 8'h01},                                  // R5
    {8'd5, KW, 8'd7, 8'h9A, 8'h00}, {8'd5, KR, 8'd7, 8'h00, 8'h00},  // R5
    {8'd5, KW, 8'd7, 8'h47, 8'h00}, {8'd5, KR, 8'd7, 8'h00, 8'h47},  // R5
    {8'd9, KW, 8'd7, 8'h00, 8'h00}, {8'd9, KW, 8'd6, 8'h02, 8'h00},  // R9
    {8'd9, KW, 8'd5, 8'h28, 8'h00}, {8'd9, KW, 8'd3, 8'h23, 8'h00},  // R9
    {8'd9, KW, 8'd2, 8'h59, 8'h00}, {8'd9, KW, 8'd1, 8'h59, 8'h00},  // R9
    {8'd9, KT, 8'd0, 8'd1,  8'h00}, {8'd9, KR, 8'd5, 8'h00, 8'h29},  // R9
    {8'd9, KR, 8'd6, 8'h00, 8'h02},                                  // R9
    {8'd9, KW, 8'd3, 8'h23, 8'h00}, {8'd9, KW, 8'd2, 8'h59, 8'h00},  // R9
    {8'd9, KW, 8'd1, 8'h59, 8'h00}, {8'd9, KT, 8'd0, 8'd1,  8'h00},  // R9
    {8'd9, KR, 8'd5, 8'h00, 8'h01}, {8'd9, KR, 8'd6, 8'h00, 8'h03}   // R9
  };

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s offset %0d actual=0x%02h expected=0x%02h", tag, a, rdata, exp);
    end
  endtask

  // preset date then run one second across midnight
  task automatic cross_midnight(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
    wr(3'd7, y); wr(3'd6, mo); wr(3'd5, d);
    wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h59);
    tk(1);
  endtask

  task automatic check_reset_state();  // R1
    chk(3'd0, 8'h90, "R1"); chk(3'd1, 8'h00, "R1");
    chk(3'd2, 8'h00, "R1"); chk(3'd3, 8'h00, "R1");
    chk(3'd4, 8'h01, "R1"); chk(3'd5, 8'h01, "R1");
    chk(3'd6, 8'h01, "R1"); chk(3'd7, 8'h00, "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][31:24])
        KW:      wr(VEC[i][18:16], VEC[i][15:8]);
        KT:      tk(int'(VEC[i][15:8]));
        default: chk(VEC[i][18:16], VEC[i][7:0], $sformatf("R%0d", VEC[i][39:32]));
      endcase
    end

    // R9 month lengths and BCD leap rule
    cross_midnight(8'h13, 8'h02, 8'h28); chk(3'd5, 8'h01, "R9"); chk(3'd6, 8'h03, "R9");
    cross_midnight(8'h12, 8'h02, 8'h28); chk(3'd5, 8'h29, "R9"); chk(3'd6, 8'h02, "R9");
    cross_midnight(8'h10, 8'h02, 8'h28); chk(3'd5, 8'h01, "R9"); chk(3'd6, 8'h03, "R9");
    cross_midnight(8'h10, 8'h04, 8'h30); chk(3'd5, 8'h01, "R9"); chk(3'd6, 8'h05, "R9");
    cross_midnight(8'h10, 8'h11, 8'h30); chk(3'd5, 8'h01, "R9"); chk(3'd6, 8'h12, "R9");
    cross_midnight(8'h10, 8'h01, 8'h31); chk(3'd5, 8'h01, "R8"); chk(3'd6, 8'h02, "R8");

    // R8 year rollover
    cross_midnight(8'h99, 8'h12, 8'h31);
    chk(3'd5, 8'h01, "R8"); chk(3'd6, 8'h01, "R8"); chk(3'd7, 8'h00, "R8");

    // R10 weekday and century
    wr(3'd4, 8'h47); chk(3'd4, 8'h47, "R10");
    cross_midnight(8'h20, 8'h05, 8'h10); chk(3'd4, 8'h41, "R10");
    wr(3'd4, 8'hFF); chk(3'd4, 8'h47, "R10");

    // R6 stop flag
    wr(3'd1, 8'h85); chk(3'd1, 8'h85, "R6");
    tk(3); chk(3'd1, 8'h85, "R6");
    wr(3'd2, 8'h10); chk(3'd2, 8'h10, "R6");
    wr(3'd1, 8'h7F); chk(3'd1, 8'h05, "R6");
    tk(1); chk(3'd1, 8'h06, "R6");
    wr(3'd1, 8'hFF); chk(3'd1, 8'h86, "R6");

    // R11 write and tick in the same cycle
    wr(3'd1, 8'h20);
    @(negedge clk);
    addr = 3'd2; wdata = 8'h33; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk(3'd2, 8'h33, "R11"); chk(3'd1, 8'h21, "R11");
    @(negedge clk);
    addr = 3'd1; wdata = 8'h40; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk(3'd1, 8'h40, "R11");

    // R1 reset in mid-run
    wr(3'd0, 8'h0F);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_reset_state();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule